// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level translation table held in memory, and it decides what a translation cache may later grant for that page. A single request carries the address and three attribute bits: write, instruction fetch and user privilege. The block also samples the control state when the request arrives: the paging enable, the supervisor write-protect switch, the table root, the large-page enable, the two supervisor guards against touching user pages (one for fetches, one for data), and the line that gates address bit 20.

While it walks, the block reads entries through a simple memory port whose latency can vary. It sets the accessed flag in entries and the dirty flag on writes, and it writes an entry back only when that entry actually changed. The walk ends in one of two ways. It can return a physical address together with read, write and execute grants, or it can return a page-fault code built from the access attributes.

The block handles one request at a time. A `done` pulse marks the cycle in which the result outputs are valid. The results then stay on the outputs until the next request is accepted.

Top module: `pgwalk_top`

## Requirements
- R1: When `cr0_pg` is 0, the result is `req_vaddr` masked per R10, with no fault, `perm_r`/`perm_w`/`perm_x` all 1, and no memory access. `done` rises in the cycle after the request is accepted.
- R2: The first entry is read at ((`cr3` with bits 11:0 cleared) + (vaddr bits 31:22 times 4)), masked per R10.
- R3: A first-level entry with bit 7 set maps a 4 MB page only when `cr4_pse` is 1. In that case the PA is {entry[31:22], vaddr[21:0]}. Otherwise the second entry is read at ((entry with bits 11:0 cleared) + vaddr[21:12]*4), masked per R10, and the PA is {entry2[31:12], vaddr[11:0]}.
- R4: If bit 0 (present) of either entry is clear, the walk faults with fault_code bit 0 = 0, and no further entry is read.
- R5: The user flag (bit 2) and the writable flag (bit 1) are the AND of both levels. A user access faults unless the user flag is set. A user write also needs the writable flag. A request with `req_fetch`=1 is never treated as a write.
- R6: A supervisor access faults when it writes to a non-writable page while `cr0_wp`=1, when it reads data from a user page while `cr4_smap`=1, or when it fetches from a user page while `cr4_smep`=1.
- R7: The accessed flag (bit 5) is set in the first-level entry and in the final entry. A write also sets the dirty flag (bit 6) in the final entry. An entry is written back only if its value changed. A protection fault leaves the final entry untouched.
- R8: `perm_w` is 1 only when the final entry is dirty after the walk. For a user access it also needs the combined writable flag. For a supervisor access it needs either the combined writable flag or `cr0_wp`=0.
- R9: On a fault, fault_code holds: bit 0 = 1 for a protection fault, bit 1 = write, bit 2 = user, bit 3 = 0, bit 4 = fetch AND `cr4_smep`. All perm outputs are 0 on a fault.
- R10: When `a20_on` is 0, bit 20 is cleared in every entry address and in the final physical address.
- R11: While `busy` is 1, new requests are ignored. `done` lasts one cycle. `mem_rd` and `mem_wr` are never both high, and each stays high with a stable address until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a translation when idle |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Access is at user privilege |
| cr0_pg | input | 1 | Paging enable |
| cr0_wp | input | 1 | Supervisor write protect |
| cr3 | input | 32 | Table root address |
| cr4_pse | input | 1 | Large-page enable |
| cr4_smep | input | 1 | Supervisor fetch guard |
| cr4_smap | input | 1 | Supervisor data guard |
| a20_on | input | 1 | Address bit 20 pass-through |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory word address (byte units) |
| mem_wdata | output | 32 | Entry write-back data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle completion of the current access |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Walk ended in a page fault |
| fault_code | output | 5 | Fault attribute bits |
| pa | output | 32 | Physical address |
| perm_r | output | 1 | Read grant |
| perm_w | output | 1 | Write grant |
| perm_x | output | 1 | Execute grant |

## Verification
The assertions assume that the control inputs (`cr0_pg`, `cr4_smep`, `a20_on`) stay unchanged from the request until `done`. They also assume that `mem_ack` pulses for exactly one cycle and only while an access is pending. The bench meets both assumptions. It changes the control bits only between walks. Its memory responder raises `mem_ack` for one cycle after a random delay of zero to two cycles, and then drops it before the next access starts.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int ENT_W = 32;
  localparam int OFF_W = 12;
  localparam int IDX_W = 10;
  localparam int EC_W  = 5;

  localparam int B_PRES = 0;
  localparam int B_RW   = 1;
  localparam int B_USR  = 2;
  localparam int B_ACC  = 5;
  localparam int B_DTY  = 6;
  localparam int B_BIG  = 7;

  localparam int EC_PROT = 0;
  localparam int EC_WR   = 1;
  localparam int EC_USR  = 2;
  localparam int EC_IFT  = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIR_RD, ST_DIR_WB, ST_TBL_RD, ST_TBL_WB, ST_DONE
  } walk_st_e;

  typedef struct packed {
    logic [ENT_W-1:0] va;
    logic [ENT_W-1:0] root;
    logic wr;
    logic fetch;
    logic user;
    logic wp;
    logic pse;
    logic smep;
    logic smap;
    logic a20;
  } walk_req_t;

  function automatic logic [ENT_W-1:0] a20_mask(input logic on, input int unsigned pos);
    logic [ENT_W-1:0] m;
    m = '1;
    m[pos] = on;
    return m;
  endfunction
endpackage

// File: rtl/pgw_addr.sv
module pgw_addr
  import pgw_pkg::*;
#(
  parameter int A20_POS = 20
) (
  input  logic             sel_tbl,
  input  logic [ENT_W-1:0] root,
  input  logic [ENT_W-1:0] dir_ent,
  input  logic [ENT_W-1:0] va,
  input  logic             a20,
  output logic [ENT_W-1:0] ent_addr
);
  localparam int PAD_W = ENT_W - IDX_W - 2;

  logic [ENT_W-1:0] base;
  logic [ENT_W-1:0] offs;

  always_comb begin
    if (sel_tbl) begin
      base = {dir_ent[ENT_W-1:OFF_W], {OFF_W{1'b0}}};
      offs = {{PAD_W{1'b0}}, va[OFF_W+IDX_W-1:OFF_W], 2'b00};
    end else begin
      base = {root[ENT_W-1:OFF_W], {OFF_W{1'b0}}};
      offs = {{PAD_W{1'b0}}, va[ENT_W-1:OFF_W+IDX_W], 2'b00};
    end
    ent_addr = (base + offs) & a20_mask(a20, A20_POS);
  end
endmodule

// File: rtl/pgw_perm.sv
module pgw_perm
  import pgw_pkg::*;
(
  input  logic [ENT_W-1:0] dir_ent,
  input  logic [ENT_W-1:0] leaf_ent,
  input  logic             wr,
  input  logic             fetch,
  input  logic             user,
  input  logic             wp,
  input  logic             smep,
  input  logic             smap,
  output logic             prot_flt,
  output logic [ENT_W-1:0] leaf_new,
  output logic             leaf_chg,
  output logic             grant_w,
  output logic [EC_W-1:0]  ec_base
);
  logic c_usr, c_rw;

  always_comb begin
    c_usr = dir_ent[B_USR] & leaf_ent[B_USR];
    c_rw  = dir_ent[B_RW] & leaf_ent[B_RW];
    if (user)
      prot_flt = !c_usr || (wr && !c_rw);
    else
      prot_flt = (!fetch && smap && c_usr) || (fetch && smep && c_usr) ||
                 (wp && wr && !c_rw);
    leaf_new = leaf_ent;
    leaf_new[B_ACC] = 1'b1;
    if (wr) leaf_new[B_DTY] = 1'b1;
    leaf_chg = (leaf_new != leaf_ent);
    grant_w  = leaf_new[B_DTY] && (user ? c_rw : (c_rw || !wp));
    ec_base  = '0;
    ec_base[EC_WR]  = wr;
    ec_base[EC_USR] = user;
    ec_base[EC_IFT] = fetch & smep;
  end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgw_pkg::*;
#(
  parameter int A20_POS = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [ENT_W-1:0] req_vaddr,
  input  logic             req_write,
  input  logic             req_fetch,
  input  logic             req_user,
  input  logic             cr0_pg,
  input  logic             cr0_wp,
  input  logic [ENT_W-1:0] cr3,
  input  logic             cr4_pse,
  input  logic             cr4_smep,
  input  logic             cr4_smap,
  input  logic             a20_on,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic [ENT_W-1:0] mem_addr,
  output logic [ENT_W-1:0] mem_wdata,
  input  logic [ENT_W-1:0] mem_rdata,
  input  logic             mem_ack,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic [EC_W-1:0]  fault_code,
  output logic [ENT_W-1:0] pa,
  output logic             perm_r,
  output logic             perm_w,
  output logic             perm_x
);
  localparam int BIG_W = OFF_W + IDX_W;

  walk_st_e         st;
  walk_req_t        rq;
  logic [ENT_W-1:0] pde_q, wb_q, res_pa, dir_sel, leaf_new, m20;
  logic             big_q, res_r, res_w, res_x, res_flt;
  logic [EC_W-1:0]  res_ec, ec_base;
  logic             prot_flt, leaf_chg, grant_w, big_now;

  assign dir_sel = (st == ST_DIR_RD) ? mem_rdata : pde_q;
  assign m20     = a20_mask(rq.a20, A20_POS);
  assign big_now = mem_rdata[B_BIG] & rq.pse;

  pgw_addr #(.A20_POS(A20_POS)) addr_i (
    .sel_tbl (st == ST_TBL_RD || st == ST_TBL_WB),
    .root    (rq.root),
    .dir_ent (pde_q),
    .va      (rq.va),
    .a20     (rq.a20),
    .ent_addr(mem_addr)
  );

  pgw_perm perm_i (
    .dir_ent (dir_sel),
    .leaf_ent(mem_rdata),
    .wr      (rq.wr),
    .fetch   (rq.fetch),
    .user    (rq.user),
    .wp      (rq.wp),
    .smep    (rq.smep),
    .smap    (rq.smap),
    .prot_flt(prot_flt),
    .leaf_new(leaf_new),
    .leaf_chg(leaf_chg),
    .grant_w (grant_w),
    .ec_base (ec_base)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      rq      <= '0;
      pde_q   <= '0;
      wb_q    <= '0;
      big_q   <= 1'b0;
      res_pa  <= '0;
      res_r   <= 1'b0;
      res_w   <= 1'b0;
      res_x   <= 1'b0;
      res_flt <= 1'b0;
      res_ec  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          rq.va    <= req_vaddr;
          rq.root  <= cr3;
          rq.wr    <= req_write & ~req_fetch;
          rq.fetch <= req_fetch;
          rq.user  <= req_user;
          rq.wp    <= cr0_wp;
          rq.pse   <= cr4_pse;
          rq.smep  <= cr4_smep;
          rq.smap  <= cr4_smap;
          rq.a20   <= a20_on;
          res_flt  <= 1'b0;
          res_ec   <= '0;
          {res_r, res_w, res_x} <= 3'b000;
          if (!cr0_pg) begin
            res_pa <= req_vaddr & a20_mask(a20_on, A20_POS);
            {res_r, res_w, res_x} <= 3'b111;
            st <= ST_DONE;
          end else begin
            st <= ST_DIR_RD;
          end
        end
        ST_DIR_RD: if (mem_ack) begin
          pde_q <= mem_rdata;
          big_q <= big_now;
          if (!mem_rdata[B_PRES]) begin
            res_flt <= 1'b1;
            res_ec  <= ec_base;
            st      <= ST_DONE;
          end else if (big_now) begin
            if (prot_flt) begin
              res_flt <= 1'b1;
              res_ec  <= ec_base | EC_W'(1);
              st      <= ST_DONE;
            end else begin
              wb_q   <= leaf_new;
              res_pa <= {mem_rdata[ENT_W-1:BIG_W], rq.va[BIG_W-1:0]} & m20;
              {res_r, res_w, res_x} <= {1'b1, grant_w, 1'b1};
              st <= leaf_chg ? ST_DIR_WB : ST_DONE;
            end
          end else begin
            wb_q <= mem_rdata | (ENT_W'(1) << B_ACC);
            st   <= mem_rdata[B_ACC] ? ST_TBL_RD : ST_DIR_WB;
          end
        end
        ST_DIR_WB: if (mem_ack) st <= big_q ? ST_DONE : ST_TBL_RD;
        ST_TBL_RD: if (mem_ack) begin
          if (!mem_rdata[B_PRES] || prot_flt) begin
            res_flt <= 1'b1;
            res_ec  <= ec_base | EC_W'(mem_rdata[B_PRES]);
            st      <= ST_DONE;
          end else begin
            wb_q   <= leaf_new;
            res_pa <= {mem_rdata[ENT_W-1:OFF_W], rq.va[OFF_W-1:0]} & m20;
            {res_r, res_w, res_x} <= {1'b1, grant_w, 1'b1};
            st <= leaf_chg ? ST_TBL_WB : ST_DONE;
          end
        end
        ST_TBL_WB: if (mem_ack) st <= ST_DONE;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  assign mem_rd     = (st == ST_DIR_RD) || (st == ST_TBL_RD);
  assign mem_wr     = (st == ST_DIR_WB) || (st == ST_TBL_WB);
  assign mem_wdata  = wb_q;
  assign busy       = (st != ST_IDLE);
  assign done       = (st == ST_DONE);
  assign fault      = res_flt;
  assign fault_code = res_ec;
  assign pa         = res_pa;
  assign perm_r     = res_r;
  assign perm_w     = res_w;
  assign perm_x     = res_x;
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk
  import pgw_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             cr0_pg,
  input logic             cr4_smep,
  input logic             a20_on,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic             mem_ack,
  input logic [ENT_W-1:0] mem_addr,
  input logic [ENT_W-1:0] mem_wdata,
  input logic             busy,
  input logic             done,
  input logic             fault,
  input logic [EC_W-1:0]  fault_code,
  input logic [ENT_W-1:0] pa,
  input logic             perm_w
);
  AST_MEM_EXCL: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr)); // R11
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_ack) |=> (mem_rd && $stable(mem_addr))); // R11
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && !mem_ack) |=> (mem_wr && $stable(mem_wdata))); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_rd && !mem_wr)); // R11
  AST_PG_OFF: assert property (@(posedge clk) disable iff (rst)
    (done && !cr0_pg) |-> (!fault && perm_w)); // R1
  AST_WB_ACC: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> mem_wdata[B_ACC]); // R7
  AST_IFT_SMEP: assert property (@(posedge clk) disable iff (rst)
    (done && fault && fault_code[EC_IFT]) |-> cr4_smep); // R9
  AST_A20_PA: assert property (@(posedge clk) disable iff (rst)
    (done && !fault && !a20_on) |-> !pa[20]); // R10
endmodule

bind pgwalk_top pgwalk_chk chk_i (.*);

// File: tb/pgwalk_top_tb_top.sv
module pgwalk_top_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, req_valid, req_write, req_fetch, req_user;
  logic [31:0] req_vaddr;
  logic c_pg, c_wp, c_pse, c_smep, c_smap, c_a20;
  logic [31:0] c_root;
  logic mem_rd, mem_wr, mem_ack, busy, done, fault, perm_r, perm_w, perm_x;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, pa;
  logic [4:0] fault_code;

  pgwalk_top dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_fetch(req_fetch), .req_user(req_user),
    .cr0_pg(c_pg), .cr0_wp(c_wp), .cr3(c_root), .cr4_pse(c_pse),
    .cr4_smep(c_smep), .cr4_smap(c_smap), .a20_on(c_a20),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .busy(busy), .done(done),
    .fault(fault), .fault_code(fault_code), .pa(pa),
    .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x)
  );

  bit [31:0] mem [bit [31:0]];
  int n_tests = 0, n_fail = 0, wr_cnt = 0;

  function automatic logic [31:0] rdm(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory responder: one-cycle ack after a random 0..2 cycle delay
  initial begin
    int lat_cnt, lat_tgt;
    lat_cnt = 0; lat_tgt = 0;
    mem_ack = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0; lat_cnt = 0;
      end else if (mem_rd || mem_wr) begin
        if (lat_cnt >= lat_tgt) begin
          if (mem_wr) begin mem[mem_addr] = mem_wdata; wr_cnt++; end
          else mem_rdata = rdm(mem_addr);
          mem_ack = 1'b1;
          lat_tgt = $urandom_range(0, 2);
        end else lat_cnt++;
      end
    end
  end

  // test vector
  logic [31:0] t_va;
  logic t_wr, t_fetch, t_user;
  // expectations
  logic e_flt, e_w, e_big, e_pres1;
  logic [4:0] e_ec;
  logic [31:0] e_pa, e_pda, e_pta, e_pde, e_pte;
  int e_wr;

  task automatic model();
    logic [31:0] m20, d, t, pt, nl;
    logic wr, pu, prw, pf;
    m20 = 32'hFFFF_FFFF; m20[20] = c_a20;
    wr = t_wr & ~t_fetch;
    e_flt = 0; e_ec = 0; e_w = 0; e_wr = 0; e_pa = 0; e_big = 0; e_pres1 = 0;
    e_pda = 0; e_pta = 0; e_pde = 0; e_pte = 0;
    if (!c_pg) begin e_pa = t_va & m20; e_w = 1; return; end
    e_pda = ({c_root[31:12], 12'h0} + {20'h0, t_va[31:22], 2'b00}) & m20;
    d = rdm(e_pda); e_pde = d;
    e_ec = {t_fetch & c_smep, 1'b0, t_user, wr, 1'b0};
    if (!d[0]) begin e_flt = 1; return; end
    e_pres1 = 1;
    e_big = d[7] & c_pse;
    if (e_big) begin
      t = d; pu = d[2]; prw = d[1];
    end else begin
      if (!d[5]) begin e_pde = d | 32'h20; e_wr++; end
      e_pta = ({d[31:12], 12'h0} + {20'h0, t_va[21:12], 2'b00}) & m20;
      t = rdm(e_pta); e_pte = t;
      if (!t[0]) begin e_flt = 1; return; end
      pu = d[2] & t[2]; prw = d[1] & t[1];
    end
    if (t_user) pf = !pu || (wr && !prw);
    else pf = (!t_fetch && c_smap && pu) || (t_fetch && c_smep && pu) || (c_wp && wr && !prw);
    if (pf) begin e_flt = 1; e_ec[0] = 1; return; end
    nl = t | 32'h20 | (wr ? 32'h40 : 32'h0);
    if (nl != t) e_wr++;
    if (e_big) e_pde = nl; else e_pte = nl;
    e_w = nl[6] && (t_user ? prw : (prw || !c_wp));
    pt = e_big ? {t[31:22], t_va[21:0]} : {t[31:12], t_va[11:0]};
    e_pa = pt & m20;
  endtask

  task automatic run(input string tag, input bit junk);
    int cyc;
    model();
    wr_cnt = 0;
    @(negedge clk);
    req_valid = 1; req_vaddr = t_va; req_write = t_wr; req_fetch = t_fetch; req_user = t_user;
    @(negedge clk);
    req_valid = junk;
    if (junk) begin req_vaddr = ~t_va; req_write = ~t_wr; req_user = ~t_user; end
    cyc = 0;
    while (!done && cyc < 500) begin @(negedge clk); cyc++; end
    req_valid = 0;
    if (!done) begin n_tests++; n_fail++; $display("FAIL R11 %s walk timeout act=0 exp=1", tag); end
    chk({tag, " R9 fault"}, {31'h0, fault}, {31'h0, e_flt});
    if (e_flt) chk({tag, " R9 fault_code"}, {27'h0, fault_code}, {27'h0, e_ec});
    else chk({tag, " R3 pa"}, pa, e_pa);
    chk({tag, " R8 perm_w"}, {31'h0, perm_w}, {31'h0, e_w});
    chk({tag, " R5 perm_rx"}, {30'h0, perm_r, perm_x}, e_flt ? 32'h0 : 32'h3);
    chk({tag, " R7 writes"}, wr_cnt, e_wr);
    if (c_pg) chk({tag, " R7 dir entry"}, rdm(e_pda), e_pde);
    if (e_pres1 && !e_big) chk({tag, " R7 tbl entry"}, rdm(e_pta), e_pte);
    @(negedge clk);
    chk({tag, " R11 idle after done"}, {30'h0, busy, done}, 32'h0);
  endtask

  task automatic setctl(input logic pg, wp, pse, smep, smap, a20, input logic [31:0] root);
    c_pg = pg; c_wp = wp; c_pse = pse; c_smep = smep; c_smap = smap; c_a20 = a20; c_root = root;
  endtask

  task automatic setacc(input logic [31:0] va, input logic wr, fe, us);
    t_va = va; t_wr = wr; t_fetch = fe; t_user = us;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    process::self().srandom(32'h5EED_1234);
    rst = 1; req_valid = 0; req_vaddr = 0; req_write = 0; req_fetch = 0; req_user = 0;
    setctl(0, 0, 0, 0, 0, 1, 0);
    repeat (3) @(negedge clk);
    chk("R11 reset outputs", {27'h0, busy, done, mem_rd, mem_wr, fault}, 32'h0);
    rst = 0;

    // R1 pass-through, R10 masking without paging
    setctl(0, 0, 0, 0, 0, 1, 0); setacc(32'h1234_5678, 1, 0, 1);
    run("R1 pg off", 0);
    chk("R1 pa literal", pa, 32'h1234_5678);
    setctl(0, 0, 0, 0, 0, 0, 0); setacc(32'h0017_0001, 0, 0, 0);
    run("R10 pg off a20", 0);
    chk("R10 pa literal", pa, 32'h0007_0001);

    // R2/R3 small page, entries clean of update needs
    mem[32'h0000_3004] = 32'h0100_5027;
    mem[32'h0100_5004] = 32'h0ABC_D067;
    setctl(1, 1, 0, 0, 0, 1, 32'h0000_3ABC); setacc(32'h0040_1123, 1, 0, 1);
    run("R2 small page", 0);
    chk("R2 pa literal", pa, 32'h0ABC_D123);

    // R3 large page, and same entry with large pages disabled
    mem[32'h0000_3004] = 32'h0AC0_00E7;
    setctl(1, 1, 1, 0, 0, 1, 32'h0000_3000); setacc(32'h0040_1123, 0, 0, 1);
    run("R3 large page", 0);
    chk("R3 pa literal", pa, 32'h0AC0_1123);
    setctl(1, 1, 0, 0, 0, 1, 32'h0000_3000);
    run("R3 pse off", 0);
    chk("R4 np code literal", {27'h0, fault_code}, 32'h4);

    // R6 supervisor write to read-only page
    mem[32'h0000_3004] = 32'h0100_5025;
    mem[32'h0100_5004] = 32'h0ABC_D065;
    setctl(1, 0, 0, 0, 0, 1, 32'h0000_3000); setacc(32'h0040_1123, 1, 0, 0);
    run("R6 wp clear", 0);
    chk("R8 sup write wp clear", {31'h0, perm_w}, 32'h1);
    setctl(1, 1, 0, 0, 0, 1, 32'h0000_3000);
    run("R6 wp set", 0);
    chk("R9 code literal", {27'h0, fault_code}, 32'h3);
    setctl(1, 0, 0, 1, 0, 1, 32'h0000_3000); setacc(32'h0040_1123, 0, 1, 0);
    run("R6 smep", 0);
    chk("R9 smep code literal", {27'h0, fault_code}, 32'h11);
    setctl(1, 0, 0, 0, 1, 1, 32'h0000_3000); setacc(32'h0040_1123, 0, 0, 0);
    run("R6 smap", 0);

    // R8 clean page: read gets no write grant, write sets dirty
    mem[32'h0000_3004] = 32'h0100_5007;
    mem[32'h0100_5004] = 32'h0ABC_D007;
    setctl(1, 1, 0, 0, 0, 1, 32'h0000_3000); setacc(32'h0040_1123, 0, 0, 1);
    run("R8 clean read", 1);
    setacc(32'h0040_1123, 1, 0, 1);
    run("R8 clean write", 1);

    // random walks
    for (int i = 0; i < 400; i++) begin
      logic [31:0] pda, pta, de, te, m20;
      setctl(($urandom_range(0, 9) != 0), $urandom_range(0, 1), $urandom_range(0, 1),
             $urandom_range(0, 1), $urandom_range(0, 1), ($urandom_range(0, 3) != 0),
             {8'h00, 24'($urandom())});
      setacc($urandom(), $urandom_range(0, 1), ($urandom_range(0, 3) == 0), $urandom_range(0, 1));
      m20 = 32'hFFFF_FFFF; m20[20] = c_a20;
      de = {7'h00, 1'b1, 24'($urandom())};
      de[0] = ($urandom_range(0, 7) != 0);
      te = $urandom(); te[0] = ($urandom_range(0, 7) != 0);
      pda = ({c_root[31:12], 12'h0} + {20'h0, t_va[31:22], 2'b00}) & m20;
      mem[pda] = de;
      pta = ({de[31:12], 12'h0} + {20'h0, t_va[21:12], 2'b00}) & m20;
      mem[pta] = te;
      run("R5 random", (i % 3) == 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule